// File: doc/BRIEF.md
# Four-Channel Payload and Signaling Bit Interleaver

This block merges four framed 2.048 Mbit/s channels into a single 16.384 Mbit/s serial back-plane stream. In each time slot, each channel gets a pair of octets. The first octet of the pair carries payload bits P1 to P4, with a low filler bit after each one. The second octet carries payload bits P5 to P8, each followed by one of the channel's four signaling bits A, B, C and D. Channel 0's pair goes first and channel 3's pair goes last. Bit 0 of every octet leaves the block first.

At the clock edge that ends each time slot, the block captures the payload byte and signaling nibble of all four channels. A one-cycle advance strobe marks that capture so the source can present the next time slot's values. A frame holds 32 time slots, which is 2048 serial bits. A frame sync pulse is high for four clock cycles around each frame boundary: the last two bits of the old frame and the first two bits of the new one. The current time-slot and bit positions are driven out for the attached logic.

After reset there is one priming cycle. In that cycle the inputs for time slot 0 are captured and the serial output stays low. The first frame starts on the next cycle, so its sync pulse covers only its first two bits.

Top module: `quad_bit_interleaver`

## Requirements
- R1: While `rst_n` is low, `ser_out`, `fsync` and `adv` are low and both position outputs are 0.
- R2: The first cycle after reset is released is a priming cycle. In it, `adv` is high, `ser_out` and `fsync` are low, and both positions are 0. The next cycle is time slot 0, bit 0 of the first frame.
- R3: From the priming cycle on, `bit_idx` counts 0 to 63, one step per clock. When it wraps, `slot_idx` steps, and `slot_idx` wraps from 31 to 0.
- R4: Bit position b of a slot belongs to channel b/16. Within a channel's 16 bits, offsets 0, 2, 4 and 6 carry P1, P2, P3 and P4, and offsets 1, 3, 5 and 7 are 0. Pk is bit 8-k of the channel's byte `pay_in[8c+7:8c]`, so P1 is bit 7.
- R5: Within a channel's 16 bits, offsets 8, 10, 12 and 14 carry P5, P6, P7 and P8. Offsets 9, 11, 13 and 15 carry A, B, C and D, where A is `sig_in[4c+3]` and D is `sig_in[4c]`.
- R6: `ser_out` carries one bit per clock in increasing bit position. Bit 0 of each octet goes first, and channel 0's octets come before those of higher channels.
- R7: `adv` is high for exactly one cycle at bit 63 of every slot, and also in the priming cycle. The inputs present at the clock edge ending an `adv` cycle are the ones sent in the following slot.
- R8: `fsync` is high exactly at slot 31 bits 62 and 63 and at slot 0 bits 0 and 1. Before the first frame it stays low, so that frame's pulse lasts only two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pay_in | input | 8*NUM_CH | Payload byte per channel, channel c at [8c+7:8c] |
| sig_in | input | 4*NUM_CH | ABCD nibble per channel, channel c at [4c+3:4c] |
| adv | output | 1 | Inputs captured at the end of this cycle |
| ser_out | output | 1 | Interleaved serial stream |
| fsync | output | 1 | Frame boundary pulse |
| slot_idx | output | clog2(SLOTS) | Current time slot |
| bit_idx | output | clog2(16*NUM_CH) | Current bit within the slot |

## Verification
The bench builds the block with its defaults: four channels and 32 slots, which gives 64-bit slots and 2048-bit frames. With these values, every channel's index field, both octet kinds and the full slot wrap from 31 to 0 appear in a run of about three frames. That run lets the bench watch the four-cycle sync straddle at two frame boundaries. A second reset applied in the middle of a frame brings back the priming cycle and the shortened first sync pulse.

// File: rtl/qbi_pkg.sv
package qbi_pkg;
   localparam int PAY_W = 8;
   localparam int SIG_W = 4;
   localparam int PAIR_BITS = 2 * PAY_W;

   // Bit at position pos of one octet; sig_oct selects the signaling octet.
   function automatic logic weave_bit(input logic [PAY_W-1:0] pay,
                                      input logic [SIG_W-1:0] sig,
                                      input logic sig_oct,
                                      input logic [2:0] pos);
      int step;
      step = int'(pos[2:1]);
      if (!pos[0])
         return pay[(sig_oct ? 3 : 7) - step];
      else if (sig_oct)
         return sig[3 - step];
      else
         return 1'b0;
   endfunction
endpackage

// File: rtl/qbi_position_counter.sv
module qbi_position_counter #(
   parameter int BPS   = 64,
   parameter int SLOTS = 32,
   localparam int BW = $clog2(BPS),
   localparam int SW = $clog2(SLOTS)
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [BW-1:0] bit_cnt,
   output logic [SW-1:0] slot_cnt,
   output logic          started,
   output logic          adv
);
   localparam logic [BW-1:0] LAST_BIT  = BW'(BPS - 1);
   localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         started  <= 1'b0;
         bit_cnt  <= '0;
         slot_cnt <= '0;
      end else if (!started) begin
         started <= 1'b1;
      end else if (bit_cnt == LAST_BIT) begin
         bit_cnt  <= '0;
         slot_cnt <= (slot_cnt == LAST_SLOT) ? '0 : slot_cnt + 1'b1;
      end else begin
         bit_cnt <= bit_cnt + 1'b1;
      end
   end

   assign adv = rst_n && (!started || bit_cnt == LAST_BIT);
endmodule

// File: rtl/qbi_slot_latch.sv
module qbi_slot_latch #(
   parameter int NUM_CH = 4,
   localparam int PW = NUM_CH * qbi_pkg::PAY_W,
   localparam int SW = NUM_CH * qbi_pkg::SIG_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [PW-1:0] pay_in,
   input  logic [SW-1:0] sig_in,
   output logic [PW-1:0] pay_q,
   output logic [SW-1:0] sig_q
);
   localparam int P = qbi_pkg::PAY_W;
   localparam int S = qbi_pkg::SIG_W;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pay_q[g*P +: P] <= '0;
            sig_q[g*S +: S] <= '0;
         end else if (load) begin
            pay_q[g*P +: P] <= pay_in[g*P +: P];
            sig_q[g*S +: S] <= sig_in[g*S +: S];
         end
      end
   end
endmodule

// File: rtl/qbi_bit_select.sv
module qbi_bit_select #(
   parameter int NUM_CH = 4,
   localparam int BW = $clog2(NUM_CH * qbi_pkg::PAIR_BITS),
   localparam int PW = NUM_CH * qbi_pkg::PAY_W,
   localparam int SW = NUM_CH * qbi_pkg::SIG_W
) (
   input  logic [PW-1:0] pay_q,
   input  logic [SW-1:0] sig_q,
   input  logic [BW-1:0] bit_cnt,
   input  logic          en,
   output logic          ser
);
   localparam int P = qbi_pkg::PAY_W;
   localparam int S = qbi_pkg::SIG_W;

   logic [NUM_CH-1:0] cand;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_weave
      assign cand[g] = qbi_pkg::weave_bit(pay_q[g*P +: P], sig_q[g*S +: S],
                                          bit_cnt[3], bit_cnt[2:0]);
   end

   assign ser = en & cand[bit_cnt[BW-1:4]];
endmodule

// File: rtl/quad_bit_interleaver.sv
module quad_bit_interleaver #(
   parameter int NUM_CH = 4,
   parameter int SLOTS  = 32,
   localparam int BPS = NUM_CH * qbi_pkg::PAIR_BITS,
   localparam int BW  = $clog2(BPS),
   localparam int SW  = $clog2(SLOTS),
   localparam int PW  = NUM_CH * qbi_pkg::PAY_W,
   localparam int GW  = NUM_CH * qbi_pkg::SIG_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] pay_in,
   input  logic [GW-1:0] sig_in,
   output logic          adv,
   output logic          ser_out,
   output logic          fsync,
   output logic [SW-1:0] slot_idx,
   output logic [BW-1:0] bit_idx
);
   if (NUM_CH < 2 || (NUM_CH & (NUM_CH - 1)) != 0) begin : g_bad_ch
      $error("NUM_CH must be a power of two, at least 2");
   end
   if (SLOTS < 2) begin : g_bad_slots
      $error("SLOTS must be at least 2");
   end

   localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);
   localparam logic [BW-1:0] LEAD_BIT  = BW'(BPS - 2);

   logic          started;
   logic [PW-1:0] pay_q;
   logic [GW-1:0] sig_q;

   qbi_position_counter #(.BPS(BPS), .SLOTS(SLOTS)) u_pos (
      .clk(clk), .rst_n(rst_n), .bit_cnt(bit_idx), .slot_cnt(slot_idx),
      .started(started), .adv(adv)
   );

   qbi_slot_latch #(.NUM_CH(NUM_CH)) u_latch (
      .clk(clk), .rst_n(rst_n), .load(adv), .pay_in(pay_in), .sig_in(sig_in),
      .pay_q(pay_q), .sig_q(sig_q)
   );

   qbi_bit_select #(.NUM_CH(NUM_CH)) u_sel (
      .pay_q(pay_q), .sig_q(sig_q), .bit_cnt(bit_idx), .en(started),
      .ser(ser_out)
   );

   assign fsync = started &&
                  ((slot_idx == '0 && bit_idx < BW'(2)) ||
                   (slot_idx == LAST_SLOT && bit_idx >= LEAD_BIT));
endmodule

// File: rtl/qbi_checker.sv
module qbi_checker #(
   parameter int NUM_CH = 4,
   parameter int SLOTS  = 32,
   localparam int BPS = NUM_CH * 16,
   localparam int BW  = $clog2(BPS),
   localparam int SW  = $clog2(SLOTS)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          adv,
   input logic          ser_out,
   input logic          fsync,
   input logic [SW-1:0] slot_idx,
   input logic [BW-1:0] bit_idx
);
   localparam logic [BW-1:0] LAST = BW'(BPS - 1);
   localparam logic [SW-1:0] LSL  = SW'(SLOTS - 1);

   always_ff @(posedge clk) begin
      if (!rst_n)
         assert_reset_quiet_R1: assert (!ser_out && !fsync && !adv &&
                                        bit_idx == '0 && slot_idx == '0);
   end

   assert_prime_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && bit_idx == '0) |-> (!ser_out && !fsync && slot_idx == '0));

   assert_prime_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && bit_idx == '0) |=> (!adv && bit_idx == '0 && slot_idx == '0));

   assert_bit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv) |=> (bit_idx == $past(bit_idx) + 1'b1 && slot_idx == $past(slot_idx)));

   assert_slot_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_idx == LAST) |=> (bit_idx == '0 &&
         slot_idx == (($past(slot_idx) == LSL) ? '0 : $past(slot_idx) + 1'b1)));

   assert_filler_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_idx[3] && bit_idx[0]) |-> !ser_out);

   assert_adv_place_R7: assert property (@(posedge clk) disable iff (!rst_n)
      adv |-> (bit_idx == LAST || (bit_idx == '0 && slot_idx == '0)));

   assert_adv_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> !adv);

   assert_sync_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fsync |-> ((slot_idx == '0 && bit_idx < BW'(2)) ||
                 (slot_idx == LSL && bit_idx >= BW'(BPS - 2))));

   assert_sync_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fsync && slot_idx == '0 && bit_idx == '0) |=> fsync);
endmodule

bind quad_bit_interleaver qbi_checker #(.NUM_CH(NUM_CH), .SLOTS(SLOTS)) u_chk (
   .clk(clk), .rst_n(rst_n), .adv(adv), .ser_out(ser_out), .fsync(fsync),
   .slot_idx(slot_idx), .bit_idx(bit_idx)
);

// File: tb/tb_quad_bit_interleaver.sv
`timescale 1ns/1ps
module tb_quad_bit_interleaver;
   localparam int NUM_CH = 4;
   localparam int SLOTS  = 32;
   localparam int BPS = NUM_CH * 16;
   localparam int PW  = NUM_CH * 8;
   localparam int GW  = NUM_CH * 4;
   localparam int BW  = $clog2(BPS);
   localparam int SW  = $clog2(SLOTS);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [PW-1:0] pay_in = '0;
   logic [GW-1:0] sig_in = '0;
   logic adv, ser_out, fsync;
   logic [SW-1:0] slot_idx;
   logic [BW-1:0] bit_idx;

   quad_bit_interleaver #(.NUM_CH(NUM_CH), .SLOTS(SLOTS)) dut (
      .clk(clk), .rst_n(rst_n), .pay_in(pay_in), .sig_in(sig_in), .adv(adv),
      .ser_out(ser_out), .fsync(fsync), .slot_idx(slot_idx), .bit_idx(bit_idx)
   );

   always #2.5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   bit mst;
   int mbit, mslot, k;
   bit pend;
   logic [BPS-1:0] mstream, cap_stream;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s at slot %0d bit %0d: actual %0d expected %0d",
                  req, mslot, mbit, act, exp);
      end
   endtask

   // Expected serial order for one slot, from R4 and R5.
   function automatic logic [BPS-1:0] build_slot(logic [PW-1:0] p, logic [GW-1:0] s);
      logic [BPS-1:0] v;
      v = '0;
      for (int ch = 0; ch < NUM_CH; ch++) begin
         for (int j = 0; j < 4; j++) begin
            v[ch*16 + 2*j]     = p[ch*8 + 7 - j];
            v[ch*16 + 2*j + 1] = 1'b0;
            v[ch*16 + 8 + 2*j] = p[ch*8 + 3 - j];
            v[ch*16 + 9 + 2*j] = s[ch*4 + 3 - j];
         end
      end
      return v;
   endfunction

   task automatic drive_next();
      k++;
      if (k % 40 == 1) begin
         pay_in = '1; sig_in = '0;       // directed: fillers next to ones
      end else if (k % 40 == 2) begin
         pay_in = '0; sig_in = '1;       // directed: signaling only
      end else begin
         pay_in = {$urandom, $urandom};
         sig_in = GW'($urandom);
      end
   endtask

   task automatic run(input int ncyc);
      @(negedge clk);
      rst_n = 1'b0;
      mst = 0; mbit = 0; mslot = 0; pend = 0;
      repeat (3) begin
         @(negedge clk);
         chk(!ser_out && !fsync && !adv, "R1 reset outputs", {ser_out, fsync, adv}, 0);
         chk(bit_idx == 0 && slot_idx == 0, "R1 reset position",
             int'(bit_idx) + int'(slot_idx), 0);
      end
      drive_next();
      rst_n = 1'b1;
      #0.5;
      chk(adv && !ser_out && !fsync, "R2 priming cycle", {adv, ser_out, fsync}, 3'b100);
      chk(bit_idx == 0 && slot_idx == 0, "R2 priming position",
          int'(bit_idx) + int'(slot_idx), 0);
      cap_stream = build_slot(pay_in, sig_in);
      pend = 1;
      for (int c = 0; c < ncyc; c++) begin
         bit exp_adv, exp_sync;
         @(negedge clk);
         if (!mst) begin
            mst = 1; mbit = 0; mslot = 0;
         end else if (mbit == BPS - 1) begin
            mbit = 0; mslot = (mslot + 1) % SLOTS;
         end else begin
            mbit++;
         end
         if (pend) begin
            mstream = cap_stream;
            pend = 0;
            drive_next();
         end
         exp_adv  = (mbit == BPS - 1);
         exp_sync = (mslot == 0 && mbit < 2) || (mslot == SLOTS - 1 && mbit >= BPS - 2);
         chk(int'(bit_idx) == mbit, "R3 bit index", int'(bit_idx), mbit);
         chk(int'(slot_idx) == mslot, "R3 slot index", int'(slot_idx), mslot);
         if ((mbit % 16) < 8)
            chk(ser_out == mstream[mbit], "R4/R6 payload octet", ser_out, mstream[mbit]);
         else
            chk(ser_out == mstream[mbit], "R5/R6 signaling octet", ser_out, mstream[mbit]);
         chk(adv == exp_adv, "R7 advance strobe", adv, exp_adv);
         chk(fsync == exp_sync, "R8 frame sync", fsync, exp_sync);
         if (exp_adv) begin
            pend = 1;
            cap_stream = build_slot(pay_in, sig_in);
         end
      end
   endtask

   initial begin
      void'($urandom(32'h5eed_0042));
      k = 0;
      run(3 * SLOTS * BPS + 5);
      run(SLOTS * BPS + 70);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(100000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete, actual 0 expected 1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule